// File: doc/BRIEF.md
# DMA Channel Status and Linking Controller

This block keeps the per-channel bookkeeping for a small set of DMA channels (eight by default). Each channel carries three status flags: a pending start flag, an active flag and a completion flag. Alongside them it holds a per-channel current-iteration counter that counts down one minor loop at a time towards the end of the major loop. A channel asks for service when software writes its start flag or when its peripheral request line is high. The transfer engine then tells the block when it begins a channel, each time bytes move, and when the minor loop of that channel ends.

At the end of each minor loop the block updates the iteration counter. It may also raise a link request that sets the start flag of another channel, or of the same channel. A link chosen for minor loops fires on every iteration except the last. A separate link chosen for the major loop fires once, on the last iteration, in its place. A read port returns the iteration count and the byte count of any channel. For the channel that is running, the byte count is the live value, which falls during the minor loop. For every other channel it is the configured value. Arbitration, address generation and bus transfers are handled elsewhere.

Top module: `dma_link_ctrl`

## Requirements
- R1: After reset all start, active and done flags are 0, every service request is 0, and iteration and byte counts read 0.
- R2: A software start pulse on a channel sets its start flag on the next clock. svc_req of a channel equals (start flag OR hw_req) AND NOT active.
- R3: An engine begin for a channel clears its start and done flags and sets its active flag on the next clock. A start request for that channel arriving in the same cycle leaves start set. At most one channel is active.
- R4: A minor-loop end on a channel whose iteration count is not 1 decrements the count by one and leaves start (unless requested), active and done all clear.
- R5: A minor-loop end on a channel whose iteration count is 1 sets done, clears active and reloads the count from the configured starting iteration.
- R6: With the minor-loop link enabled, a non-final minor-loop end sets the start flag of the configured target on the next clock. The target may be the channel itself.
- R7: On the final iteration, the major-loop link (when enabled) sets its target's start flag once, and the minor-loop link does not fire.
- R8: A link and a software start pulse that reach the same channel in the same cycle leave its start flag set, as one request.
- R9: On begin, the live byte count loads the channel's configured byte count. Each engine beat subtracts its byte amount, saturating at 0. rd_nbytes shows the live count when the selected channel is active and the configured count otherwise.
- R10: rd_citer returns the current iteration count of the channel selected by rd_ch.
- R11: A configuration write loads a channel's starting and current iteration counts, byte count and both link selections, effective on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | CH_W | Channel being configured |
| cfg_biter | input | ITER_W | Starting iteration count (must be at least 1) |
| cfg_nbytes | input | NB_W | Bytes per minor loop |
| cfg_mlink_en | input | 1 | Enable link at non-final minor-loop ends |
| cfg_mlink_ch | input | CH_W | Target of the minor-loop link |
| cfg_jlink_en | input | 1 | Enable link at major-loop end |
| cfg_jlink_ch | input | CH_W | Target of the major-loop link |
| sw_start | input | N | Software start pulses, one bit per channel |
| hw_req | input | N | Peripheral request lines |
| eng_begin | input | 1 | Engine begins channel eng_ch |
| eng_ch | input | CH_W | Channel the engine is serving |
| eng_beat | input | 1 | Bytes moved this cycle |
| eng_bytes | input | NB_W | Number of bytes moved by the beat |
| eng_minor_done | input | 1 | Minor loop of eng_ch has ended |
| svc_req | output | N | Per-channel service request |
| st_start | output | N | Start flags |
| st_active | output | N | Active flags |
| st_done | output | N | Done flags |
| rd_ch | input | CH_W | Channel selected for reading |
| rd_citer | output | ITER_W | Current iteration count of rd_ch |
| rd_nbytes | output | NB_W | Live or configured byte count of rd_ch |

## Verification
The assertions rely on the engine behaving well. It begins a channel only while no channel is active, and it sends beats and a minor-loop end only for the channel it began. A begin and a minor-loop end never fall in the same cycle. No channel is configured while it runs, and its starting iteration is at least 1 before it runs. The stimulus keeps to these rules with a small engine in the bench. That engine picks a requesting channel in rotating order, sends one to four beats and then ends the minor loop. All channels are configured before any start pulse or peripheral request is driven. Software start pulses are sometimes aimed at the predicted link target at the moment a minor loop ends, so that the coincident case is exercised.

// File: rtl/dma_link_pkg.sv
// Package: shared kinds for the DMA channel status and linking controller.
// Assumes nothing beyond IEEE 1800-2017 packages.
package dma_link_pkg;

    // Kind of link a channel raises when its minor loop ends.
    typedef enum logic [1:0] {
        LK_NONE  = 2'd0,
        LK_MINOR = 2'd1,
        LK_MAJOR = 2'd2
    } link_kind_t;

    // Pick which link fires: the major link on the final iteration, else the minor link.
    function automatic link_kind_t link_pick(input logic is_final,
                                             input logic minor_en,
                                             input logic major_en);
        if (is_final)
            return major_en ? LK_MAJOR : LK_NONE;
        return minor_en ? LK_MINOR : LK_NONE;
    endfunction

endpackage

// File: rtl/dma_chan_state.sv
// Module: status flags, iteration counter and link configuration of one channel.
// Assumes go_i and minor_done_i never coincide, minor_done_i only while active,
// and cfg_we only while the channel is idle with cfg_biter >= 1.
module dma_chan_state
    import dma_link_pkg::*;
#(
    parameter int ITER_W = 9,
    parameter int NB_W   = 16,
    parameter int CH_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ITER_W-1:0] cfg_biter,
    input  logic [NB_W-1:0]   cfg_nbytes,
    input  logic              cfg_mlink_en,
    input  logic [CH_W-1:0]   cfg_mlink_ch,
    input  logic              cfg_jlink_en,
    input  logic [CH_W-1:0]   cfg_jlink_ch,
    input  logic              go_i,
    input  logic              minor_done_i,
    input  logic              set_start_i,
    output logic              start_o,
    output logic              active_o,
    output logic              done_o,
    output logic [ITER_W-1:0] citer_o,
    output logic [NB_W-1:0]   nbytes_o,
    output logic              link_fire_o,
    output logic [CH_W-1:0]   link_tgt_o
);

    logic [ITER_W-1:0] biter_q;
    logic              mlink_en_q;
    logic [CH_W-1:0]   mlink_ch_q;
    logic              jlink_en_q;
    logic [CH_W-1:0]   jlink_ch_q;
    logic              is_final;
    logic              major_end;
    logic              minor_end;
    link_kind_t        kind;

    // Final iteration marker and end-of-loop events.
    always_comb begin
        is_final  = (citer_o == ITER_W'(1));
        major_end = minor_done_i && is_final;
        minor_end = minor_done_i && !is_final;
        kind      = link_pick(is_final, mlink_en_q, jlink_en_q);
    end

    // Link request towards the router, valid in the minor-loop-end cycle.
    always_comb begin
        link_fire_o = minor_done_i && (kind != LK_NONE);
        link_tgt_o  = (kind == LK_MAJOR) ? jlink_ch_q : mlink_ch_q;
    end

    // Configuration storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            biter_q    <= '0;
            nbytes_o   <= '0;
            mlink_en_q <= 1'b0;
            mlink_ch_q <= '0;
            jlink_en_q <= 1'b0;
            jlink_ch_q <= '0;
        end else if (cfg_we) begin
            biter_q    <= cfg_biter;
            nbytes_o   <= cfg_nbytes;
            mlink_en_q <= cfg_mlink_en;
            mlink_ch_q <= cfg_mlink_ch;
            jlink_en_q <= cfg_jlink_en;
            jlink_ch_q <= cfg_jlink_ch;
        end
    end

    // Current iteration: load on config, count down per minor loop, reload at major end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            citer_o <= '0;
        else if (cfg_we)
            citer_o <= cfg_biter;
        else if (major_end)
            citer_o <= biter_q;
        else if (minor_end)
            citer_o <= citer_o - ITER_W'(1);
    end

    // Start flag: a new request wins over the clear that a begin makes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            start_o <= 1'b0;
        else if (set_start_i)
            start_o <= 1'b1;
        else if (go_i)
            start_o <= 1'b0;
    end

    // Active flag: set on begin, cleared at any minor-loop end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active_o <= 1'b0;
        else if (go_i)
            active_o <= 1'b1;
        else if (minor_done_i)
            active_o <= 1'b0;
    end

    // Done flag: cleared on begin, set when the major loop ends.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_o <= 1'b0;
        else if (go_i)
            done_o <= 1'b0;
        else if (major_end)
            done_o <= 1'b1;
    end

    AST_BEGIN_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        go_i |=> active_o && !done_o); // R3
    AST_ACTIVE_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        active_o |-> !done_o); // R3
    AST_MINOR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        minor_end && !cfg_we |=> !active_o && !done_o && citer_o == $past(citer_o) - ITER_W'(1)); // R4
    AST_MAJOR_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        major_end && !cfg_we |=> done_o && !active_o && citer_o == $past(biter_q)); // R5
    AST_REQUEST_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        set_start_i |=> start_o); // R8

endmodule

// File: rtl/dma_link_router.sv
// Module: turns per-channel link requests into start-set pulses on target channels.
// Assumes several links may aim at one target; they merge into one request.
module dma_link_router #(
    parameter int N    = 8,
    parameter int CH_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N-1:0]            fire_i,
    input  logic [N-1:0][CH_W-1:0]  tgt_i,
    output logic [N-1:0]            set_o
);

    // Scatter each firing link onto its target bit.
    always_comb begin
        set_o = '0;
        for (int s = 0; s < N; s++) begin
            if (fire_i[s])
                set_o[tgt_i[s]] = 1'b1;
        end
    end

    AST_LINK_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(set_o) <= $countones(fire_i)); // R6
    AST_LINK_SOME: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i != '0) |-> (set_o != '0)); // R7

endmodule

// File: rtl/dma_live_count.sv
// Module: working byte count of the channel being executed.
// Assumes a begin and a beat do not occur in the same cycle.
module dma_live_count #(
    parameter int NB_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_i,
    input  logic [NB_W-1:0] load_val_i,
    input  logic            beat_i,
    input  logic [NB_W-1:0] beat_bytes_i,
    output logic [NB_W-1:0] live_o
);

    // Load on begin, then subtract each beat with saturation at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            live_o <= '0;
        else if (load_i)
            live_o <= load_val_i;
        else if (beat_i)
            live_o <= (live_o > beat_bytes_i) ? (live_o - beat_bytes_i) : '0;
    end

    AST_LIVE_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> live_o <= $past(live_o)); // R9
    AST_LIVE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> live_o == $past(load_val_i)); // R9

endmodule

// File: rtl/dma_link_ctrl.sv
// Module: top of the DMA channel status and linking controller.
// Assumes one channel runs at a time, begin only when none is active,
// beats and minor-loop ends only for the channel begun.
module dma_link_ctrl #(
    parameter int N      = 8,
    parameter int ITER_W = 9,
    parameter int NB_W   = 16,
    localparam int CH_W  = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CH_W-1:0]   cfg_ch,
    input  logic [ITER_W-1:0] cfg_biter,
    input  logic [NB_W-1:0]   cfg_nbytes,
    input  logic              cfg_mlink_en,
    input  logic [CH_W-1:0]   cfg_mlink_ch,
    input  logic              cfg_jlink_en,
    input  logic [CH_W-1:0]   cfg_jlink_ch,
    input  logic [N-1:0]      sw_start,
    input  logic [N-1:0]      hw_req,
    input  logic              eng_begin,
    input  logic [CH_W-1:0]   eng_ch,
    input  logic              eng_beat,
    input  logic [NB_W-1:0]   eng_bytes,
    input  logic              eng_minor_done,
    output logic [N-1:0]      svc_req,
    output logic [N-1:0]      st_start,
    output logic [N-1:0]      st_active,
    output logic [N-1:0]      st_done,
    input  logic [CH_W-1:0]   rd_ch,
    output logic [ITER_W-1:0] rd_citer,
    output logic [NB_W-1:0]   rd_nbytes
);

    logic [N-1:0]              link_fire;
    logic [N-1:0][CH_W-1:0]    link_tgt;
    logic [N-1:0]              link_set;
    logic [N-1:0]              set_start;
    logic [N-1:0][ITER_W-1:0]  citer;
    logic [N-1:0][NB_W-1:0]    nbytes_cfg;
    logic [NB_W-1:0]           live;

    // Software pulses and link pulses merge into one request per channel.
    always_comb set_start = sw_start | link_set;

    generate
        for (genvar c = 0; c < N; c++) begin : g_chan
            dma_chan_state #(
                .ITER_W(ITER_W),
                .NB_W  (NB_W),
                .CH_W  (CH_W)
            ) u_chan (
                .clk          (clk),
                .rst_n        (rst_n),
                .cfg_we       (cfg_we && (cfg_ch == CH_W'(c))),
                .cfg_biter    (cfg_biter),
                .cfg_nbytes   (cfg_nbytes),
                .cfg_mlink_en (cfg_mlink_en),
                .cfg_mlink_ch (cfg_mlink_ch),
                .cfg_jlink_en (cfg_jlink_en),
                .cfg_jlink_ch (cfg_jlink_ch),
                .go_i         (eng_begin && (eng_ch == CH_W'(c))),
                .minor_done_i (eng_minor_done && (eng_ch == CH_W'(c))),
                .set_start_i  (set_start[c]),
                .start_o      (st_start[c]),
                .active_o     (st_active[c]),
                .done_o       (st_done[c]),
                .citer_o      (citer[c]),
                .nbytes_o     (nbytes_cfg[c]),
                .link_fire_o  (link_fire[c]),
                .link_tgt_o   (link_tgt[c])
            );
        end
    endgenerate

    dma_link_router #(
        .N   (N),
        .CH_W(CH_W)
    ) u_router (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire_i (link_fire),
        .tgt_i  (link_tgt),
        .set_o  (link_set)
    );

    dma_live_count #(
        .NB_W(NB_W)
    ) u_live (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (eng_begin),
        .load_val_i   (nbytes_cfg[eng_ch]),
        .beat_i       (eng_beat),
        .beat_bytes_i (eng_bytes),
        .live_o       (live)
    );

    // Service requests from pending start flags or peripheral lines of idle channels.
    always_comb svc_req = (st_start | hw_req) & ~st_active;

    // Read port: live byte count for the running channel, stored value otherwise.
    always_comb begin
        rd_citer  = citer[rd_ch];
        rd_nbytes = st_active[rd_ch] ? live : nbytes_cfg[rd_ch];
    end

    AST_ONE_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(st_active)); // R3
    AST_SW_START_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        sw_start[0] |=> st_start[0]); // R2
    AST_RUNNING_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_req & st_active) == '0); // R2

endmodule

// File: tb/sim_dma_link_ctrl.sv
module sim_dma_link_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int IW = 9;
    localparam int NW = 16;
    localparam int CW = 3;

    logic clk = 1'b0;
    logic rst_n;
    logic cfg_we;
    logic [CW-1:0] cfg_ch;
    logic [IW-1:0] cfg_biter;
    logic [NW-1:0] cfg_nbytes;
    logic cfg_mlink_en, cfg_jlink_en;
    logic [CW-1:0] cfg_mlink_ch, cfg_jlink_ch;
    logic [N-1:0] sw_start, hw_req;
    logic eng_begin, eng_beat, eng_minor_done;
    logic [CW-1:0] eng_ch, rd_ch;
    logic [NW-1:0] eng_bytes;
    logic [N-1:0] svc_req, st_start, st_active, st_done;
    logic [IW-1:0] rd_citer;
    logic [NW-1:0] rd_nbytes;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    // Reference model state
    int m_start[N], m_active[N], m_done[N], m_citer[N], m_biter[N], m_nb[N];
    int m_mle[N], m_mlt[N], m_jle[N], m_jlt[N];
    int m_live;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_link_ctrl #(.N(N), .ITER_W(IW), .NB_W(NW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_biter(cfg_biter), .cfg_nbytes(cfg_nbytes),
        .cfg_mlink_en(cfg_mlink_en), .cfg_mlink_ch(cfg_mlink_ch),
        .cfg_jlink_en(cfg_jlink_en), .cfg_jlink_ch(cfg_jlink_ch),
        .sw_start(sw_start), .hw_req(hw_req), .eng_begin(eng_begin),
        .eng_ch(eng_ch), .eng_beat(eng_beat), .eng_bytes(eng_bytes),
        .eng_minor_done(eng_minor_done), .svc_req(svc_req),
        .st_start(st_start), .st_active(st_active), .st_done(st_done),
        .rd_ch(rd_ch), .rd_citer(rd_citer), .rd_nbytes(rd_nbytes));

    // Behavioural model: updates on each rising edge from the inputs held since the falling edge.
    always @(posedge clk) begin
        int link[N];
        int c;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_start[i] = 0; m_active[i] = 0; m_done[i] = 0; m_citer[i] = 0;
                m_biter[i] = 0; m_nb[i] = 0; m_mle[i] = 0; m_mlt[i] = 0;
                m_jle[i] = 0; m_jlt[i] = 0;
            end
            m_live = 0;
        end else begin
            for (int i = 0; i < N; i++) link[i] = 0;
            c = int'(eng_ch);
            if (eng_minor_done) begin
                m_active[c] = 0;
                if (m_citer[c] == 1) begin
                    m_done[c] = 1;
                    m_citer[c] = m_biter[c];
                    if (m_jle[c] != 0) link[m_jlt[c]] = 1;
                end else begin
                    m_citer[c] = m_citer[c] - 1;
                    if (m_mle[c] != 0) link[m_mlt[c]] = 1;
                end
            end
            if (eng_begin) begin
                m_start[c] = 0; m_active[c] = 1; m_done[c] = 0; m_live = m_nb[c];
            end else if (eng_beat) begin
                m_live = (m_live > int'(eng_bytes)) ? m_live - int'(eng_bytes) : 0;
            end
            for (int i = 0; i < N; i++)
                if (sw_start[i] || link[i] != 0) m_start[i] = 1;
            if (cfg_we) begin
                c = int'(cfg_ch);
                m_biter[c] = int'(cfg_biter); m_citer[c] = int'(cfg_biter);
                m_nb[c] = int'(cfg_nbytes);
                m_mle[c] = int'(cfg_mlink_en); m_mlt[c] = int'(cfg_mlink_ch);
                m_jle[c] = int'(cfg_jlink_en); m_jlt[c] = int'(cfg_jlink_ch);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d",
                     req, what, act, exp, cycles);
        end
    endtask

    function automatic int msvc(input int i);
        return ((m_start[i] != 0 || hw_req[i]) && m_active[i] == 0) ? 1 : 0;
    endfunction

    // Compare every output against the model.
    task automatic compare_all(input string citer_tag);
        int r;
        for (int i = 0; i < N; i++) begin
            chk(st_start[i] == (m_start[i] != 0), "R2/R3/R6/R7/R8", $sformatf("start[%0d]", i),
                int'(st_start[i]), m_start[i]);
            chk(st_active[i] == (m_active[i] != 0), "R3", $sformatf("active[%0d]", i),
                int'(st_active[i]), m_active[i]);
            chk(st_done[i] == (m_done[i] != 0), "R5", $sformatf("done[%0d]", i),
                int'(st_done[i]), m_done[i]);
            chk(svc_req[i] == (msvc(i) != 0), "R2", $sformatf("svc_req[%0d]", i),
                int'(svc_req[i]), msvc(i));
        end
        r = int'(rd_ch);
        chk(int'(rd_citer) == m_citer[r], citer_tag, "rd_citer", int'(rd_citer), m_citer[r]);
        chk(int'(rd_nbytes) == ((m_active[r] != 0) ? m_live : m_nb[r]), "R9", "rd_nbytes",
            int'(rd_nbytes), (m_active[r] != 0) ? m_live : m_nb[r]);
    endtask

    // Watchdog: an overrun counts as a failed check and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    always @(posedge clk) cycles++;

    initial begin
        bit busy;
        int beats, rr, pick;
        rst_n = 1'b0; cfg_we = 0; cfg_ch = '0; cfg_biter = '0; cfg_nbytes = '0;
        cfg_mlink_en = 0; cfg_mlink_ch = '0; cfg_jlink_en = 0; cfg_jlink_ch = '0;
        sw_start = '0; hw_req = '0; eng_begin = 0; eng_ch = '0; eng_beat = 0;
        eng_bytes = '0; eng_minor_done = 0; rd_ch = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(st_start == '0 && st_active == '0 && st_done == '0, "R1", "flags",
            int'(st_start | st_active | st_done), 0);
        chk(svc_req == '0, "R1", "svc_req", int'(svc_req), 0);
        chk(rd_citer == '0 && rd_nbytes == '0, "R1", "counts", int'(rd_citer) + int'(rd_nbytes), 0);
        rst_n = 1'b1;
        // R11: configure every channel, reading each back through the read port
        for (int c = 0; c < N; c++) begin
            cfg_we = 1; cfg_ch = CW'(c); cfg_biter = IW'(1 + c % 4);
            cfg_nbytes = NW'(16 + 4 * c);
            cfg_mlink_en = (c % 2 == 0); cfg_mlink_ch = CW'((c + 1) % N);
            cfg_jlink_en = (c < 6); cfg_jlink_ch = (c % 2 == 0) ? CW'(c) : CW'((c + 3) % N);
            rd_ch = CW'(c);
            @(negedge clk);
            cfg_we = 0;
            compare_all("R11");
        end
        // Randomised engine run with cycle-by-cycle comparison (R4/R10 on the count)
        busy = 0; beats = 0; rr = 0;
        for (int t = 0; t < 6000; t++) begin
            eng_begin = 0; eng_beat = 0; eng_minor_done = 0; sw_start = '0;
            if ($urandom_range(15) == 0) hw_req[$urandom_range(N - 1)] ^= 1'b1;
            if ($urandom_range(9) == 0) sw_start[$urandom_range(N - 1)] = 1'b1;
            if (busy) begin
                if (beats > 0) begin
                    eng_beat = 1; eng_bytes = NW'($urandom_range(12, 1)); beats--;
                end else begin
                    eng_minor_done = 1; busy = 0;
                    // R8: aim a software start at the link target in the same cycle
                    if ($urandom_range(1) == 0) begin
                        pick = (m_citer[eng_ch] == 1) ? m_jlt[eng_ch] : m_mlt[eng_ch];
                        sw_start[pick] = 1'b1;
                    end
                end
            end else begin
                for (int k = 0; k < N; k++) begin
                    pick = (rr + k) % N;
                    if (!busy && msvc(pick) != 0) begin
                        eng_begin = 1; eng_ch = CW'(pick); busy = 1;
                        beats = $urandom_range(4, 1); rr = (pick + 1) % N;
                    end
                end
            end
            rd_ch = (t % 2 == 0) ? eng_ch : CW'($urandom_range(N - 1));
            @(negedge clk);
            compare_all("R4/R10");
        end
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule